// File: doc/BRIEF.md
# UART Host Register File with Interrupt Selection

This block is the host-facing register set of a 16550-style serial port. A byte-wide bus with a 3-bit offset reaches eight register locations: receive/transmit data, interrupt enable, interrupt identification and FIFO control, line control, modem control, line status, modem status and scratch. A divisor latch is overlaid on the first two offsets. A small queue holds received bytes until the host reads them. Pending flags for character timeout, received data and transmitter empty are ranked by a fixed priority. The winner appears in the identification register and drives one level interrupt line.

No serialiser is present. A byte written to the data register leaves on a one-cycle valid/data output and immediately counts as transmitted, so the transmit-empty condition rises at once. Received bytes arrive on a valid/data input. A loopback bit in modem control routes transmitted bytes back into the receive queue. Software setup code can therefore exercise its receive path without any external traffic.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line status reads 0x60, identification reads 0x01, `irq` and `tx_valid` are low, and line control, modem control, interrupt enable, scratch and the divisor bytes read 0.
- R2: While line control bit 7 is 1, offsets 0 and 1 read and write the divisor low and high bytes. Interrupt enable, the receive queue and the transmit output are then untouched by those offsets.
- R3: The interrupt enable register stores only bits 3:0, and offset 1 reads them back with bits 7:4 as 0. Bit 0 enables both receive sources and bit 1 enables transmit-empty.
- R4: The identification code is 0x0C for a pending, enabled character timeout. Otherwise it is 0x04 for received data, then 0x02 for transmit-empty, and 0x01 when nothing qualifies. `irq` is high exactly when the code is not 0x01, in the same cycle the flags and enables change.
- R5: Reading offset 2 returns the code in bits 3:0, with bits 7:6 set when FIFO control bit 0 is 1. A read that reports 0x02 clears the transmit-empty pending flag.
- R6: An accepted received byte sets line status bit 0. It raises character-timeout pending when FIFO control bit 0 is 1, and received-data pending otherwise.
- R7: Reading offset 0 returns the oldest queued byte and removes it, or returns 0 when the queue is empty. When the queue becomes empty, line status bit 0 and both receive pending flags clear.
- R8: Writing offset 0 sets transmit-empty pending. With modem control bit 4 at 0, `tx_valid` is high for exactly the next cycle with the byte on `tx_data`. With bit 4 at 1, the byte enters the receive queue and `tx_valid` stays low.
- R9: An interrupt enable write that sets bit 1 while the stored bit 1 is 0 raises transmit-empty pending.
- R10: Offset 7 reads back the last byte written. Line control and modem control read back as written. Writes to offset 5 have no effect on line status.
- R11: The queue holds `RXQ_DEPTH` bytes. A byte arriving while it is full is dropped, and the stored bytes keep their order.
- R12: While loopback is on, `rx_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; read side effects apply at the clock edge |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmitted byte strobe |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with `RXQ_DEPTH` set to 4 rather than 16. That lets a handful of injected bytes fill the queue, so the drop-on-full rule and the preservation of queued contents are checked directly. The smaller depth also brings the pointer wrap and the full-to-empty transition into reach with short sequences. The same build covers the priority ladder, because receive and transmit sources can be made pending together and then drained one by one.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_IEN  = 3'd1;
   localparam logic [2:0] OFS_IDF  = 3'd2;
   localparam logic [2:0] OFS_LCTL = 3'd3;
   localparam logic [2:0] OFS_MCTL = 3'd4;
   localparam logic [2:0] OFS_LSTA = 3'd5;
   localparam logic [2:0] OFS_MSTA = 3'd6;
   localparam logic [2:0] OFS_SCR  = 3'd7;

   localparam logic [3:0] CODE_TOUT = 4'hC;
   localparam logic [3:0] CODE_RXD  = 4'h4;
   localparam logic [3:0] CODE_TXE  = 4'h2;
   localparam logic [3:0] CODE_NONE = 4'h1;

   localparam logic [7:0] LSTA_IDLE = 8'h60;
endpackage

// File: rtl/uart_rf_rxq.sv
module uart_rf_rxq #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    din,
   input  logic             pop,
   output logic [DW-1:0]    head,
   output logic [$clog2(DEPTH):0] level,
   output logic             empty,
   output logic             full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_rf_rxq: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end
endmodule

// File: rtl/uart_rf_intsel.sv
module uart_rf_intsel
   import uart_rf_pkg::*;
(
   input  logic       pend_tout,
   input  logic       pend_rxd,
   input  logic       pend_txe,
   input  logic       en_rx,
   input  logic       en_tx,
   output logic [3:0] code,
   output logic       irq
);
   always_comb begin
      if (pend_tout && en_rx)     code = CODE_TOUT;
      else if (pend_rxd && en_rx) code = CODE_RXD;
      else if (pend_txe && en_tx) code = CODE_TXE;
      else                        code = CODE_NONE;
   end

   assign irq = (code != CODE_NONE);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
   import uart_rf_pkg::*;
#(
   parameter int RXQ_DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   output logic       irq
);
   localparam int QCW = $clog2(RXQ_DEPTH) + 1;

   logic [7:0] lctl, mctl, scr, div_lo, div_hi;
   logic [3:0] ien;
   logic       fifo_on;
   logic       pend_tout, pend_rxd, pend_txe;
   logic       dlab, loop;
   logic       wr_data, wr_ien, rd_data, rd_idf;
   logic       q_push, q_empty, q_full, q_accept, q_take, q_drain;
   logic [7:0] q_din, q_head;
   logic [QCW-1:0] q_level;
   logic [3:0] idf_code;

   assign dlab    = lctl[7];
   assign loop    = mctl[4];
   assign wr_data = bus_wr && bus_addr == OFS_DATA && !dlab;
   assign wr_ien  = bus_wr && bus_addr == OFS_IEN  && !dlab;
   assign rd_data = bus_rd && bus_addr == OFS_DATA && !dlab;
   assign rd_idf  = bus_rd && bus_addr == OFS_IDF;

   assign q_push   = loop ? wr_data : rx_valid;
   assign q_din    = loop ? bus_wdata : rx_data;
   assign q_accept = q_push && !q_full;
   assign q_take   = rd_data && !q_empty;
   assign q_drain  = q_take && q_level == QCW'(1) && !q_accept;

   uart_rf_rxq #(.DEPTH(RXQ_DEPTH), .DW(8)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   (q_din),
      .pop   (rd_data),
      .head  (q_head),
      .level (q_level),
      .empty (q_empty),
      .full  (q_full)
   );

   uart_rf_intsel u_intsel (
      .pend_tout (pend_tout),
      .pend_rxd  (pend_rxd),
      .pend_txe  (pend_txe),
      .en_rx     (ien[0]),
      .en_tx     (ien[1]),
      .code      (idf_code),
      .irq       (irq)
   );

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lctl <= '0; mctl <= '0; scr <= '0;
         div_lo <= '0; div_hi <= '0; ien <= '0; fifo_on <= 1'b0;
      end else if (bus_wr) begin
         case (bus_addr)
            OFS_DATA: if (dlab) div_lo <= bus_wdata;
            OFS_IEN:  if (dlab) div_hi <= bus_wdata; else ien <= bus_wdata[3:0];
            OFS_IDF:  fifo_on <= bus_wdata[0];
            OFS_LCTL: lctl <= bus_wdata;
            OFS_MCTL: mctl <= bus_wdata;
            OFS_SCR:  scr <= bus_wdata;
            default:  ;
         endcase
      end
   end

   // pending flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_tout <= 1'b0;
         pend_rxd  <= 1'b0;
         pend_txe  <= 1'b1;
      end else begin
         if (q_drain) begin
            pend_tout <= 1'b0;
            pend_rxd  <= 1'b0;
         end else if (q_push) begin
            if (fifo_on) pend_tout <= 1'b1;
            else         pend_rxd  <= 1'b1;
         end
         if (wr_data || (wr_ien && !ien[1] && bus_wdata[1]))
            pend_txe <= 1'b1;
         else if (rd_idf && idf_code == CODE_TXE)
            pend_txe <= 1'b0;
      end
   end

   // transmit output
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         tx_valid <= wr_data && !loop;
         if (wr_data && !loop) tx_data <= bus_wdata;
      end
   end

   always_comb begin
      case (bus_addr)
         OFS_DATA: bus_rdata = dlab ? div_lo : (q_empty ? 8'h00 : q_head);
         OFS_IEN:  bus_rdata = dlab ? div_hi : {4'h0, ien};
         OFS_IDF:  bus_rdata = {fifo_on, fifo_on, 2'b00, idf_code};
         OFS_LCTL: bus_rdata = lctl;
         OFS_MCTL: bus_rdata = mctl;
         OFS_LSTA: bus_rdata = LSTA_IDLE | {7'h0, !q_empty};
         OFS_SCR:  bus_rdata = scr;
         default:  bus_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
   parameter int DEPTH = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic [2:0] bus_addr,
   input logic [7:0] bus_wdata,
   input logic       rx_valid,
   input logic       tx_valid,
   input logic       irq,
   input logic       dlab,
   input logic       loop,
   input logic [$clog2(DEPTH):0] q_level,
   input logic       pend_tout,
   input logic       pend_rxd,
   input logic       pend_txe,
   input logic [3:0] ien,
   input logic [3:0] idf_code
);
   p_tx_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(bus_wr && bus_addr == 3'd0 && !dlab && !loop));

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      q_level <= ($clog2(DEPTH) + 1)'(DEPTH));

   p_rx_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !loop |=> q_level != '0);

   p_empty_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q_level == '0 |-> !pend_tout && !pend_rxd);

   p_txe_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_txe && ien[1] |-> irq);

   p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !((pend_tout || pend_rxd) && ien[0]) && !(pend_txe && ien[1]) |-> !irq);

   p_idf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == 3'd2 && idf_code == 4'h2 |=> !pend_txe);

   p_ien_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == 3'd1 && !dlab && !ien[1] && bus_wdata[1] |=> pend_txe);

   p_dlab_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == 3'd1 && dlab |=> $stable(ien));
endmodule

bind uart_regfile uart_regfile_chk #(.DEPTH(RXQ_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .rx_valid  (rx_valid),
   .tx_valid  (tx_valid),
   .irq       (irq),
   .dlab      (dlab),
   .loop      (loop),
   .q_level   (q_level),
   .pend_tout (pend_tout),
   .pend_rxd  (pend_rxd),
   .pend_txe  (pend_txe),
   .ien       (ien),
   .idf_code  (idf_code)
);

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4;
   localparam int NVEC = 36;

   // vector: {req[3:0], op[1:0], addr[2:0], data[7:0], expect[7:0]}
   // op 0 = bus write, 1 = bus read and compare, 2 = received byte
   localparam logic [24:0] VEC [NVEC] = '{
      {4'd2,  2'd0, 3'd3, 8'h83, 8'h00},  // R2 divisor access on
      {4'd2,  2'd0, 3'd0, 8'h34, 8'h00},
      {4'd2,  2'd0, 3'd1, 8'h12, 8'h00},
      {4'd2,  2'd1, 3'd0, 8'h00, 8'h34},
      {4'd2,  2'd1, 3'd1, 8'h00, 8'h12},
      {4'd10, 2'd0, 3'd3, 8'h03, 8'h00},
      {4'd2,  2'd1, 3'd1, 8'h00, 8'h00},  // R2 enable register untouched
      {4'd10, 2'd1, 3'd3, 8'h00, 8'h03},
      {4'd3,  2'd0, 3'd1, 8'hFF, 8'h00},
      {4'd3,  2'd1, 3'd1, 8'h00, 8'h0F},  // R3 low nibble only
      {4'd5,  2'd1, 3'd2, 8'h00, 8'h02},  // R5 reports and clears txe
      {4'd5,  2'd1, 3'd2, 8'h00, 8'h01},
      {4'd6,  2'd2, 3'd0, 8'h41, 8'h00},
      {4'd6,  2'd1, 3'd5, 8'h00, 8'h61},  // R6 data ready
      {4'd6,  2'd1, 3'd2, 8'h00, 8'h04},
      {4'd5,  2'd0, 3'd2, 8'h01, 8'h00},
      {4'd6,  2'd2, 3'd0, 8'h42, 8'h00},
      {4'd4,  2'd1, 3'd2, 8'h00, 8'hCC},  // R4 timeout outranks rx data
      {4'd7,  2'd1, 3'd0, 8'h00, 8'h41},  // R7 oldest first
      {4'd7,  2'd1, 3'd2, 8'h00, 8'hCC},
      {4'd7,  2'd1, 3'd0, 8'h00, 8'h42},
      {4'd7,  2'd1, 3'd2, 8'h00, 8'hC1},
      {4'd7,  2'd1, 3'd5, 8'h00, 8'h60},
      {4'd7,  2'd1, 3'd0, 8'h00, 8'h00},  // R7 empty read
      {4'd10, 2'd0, 3'd7, 8'h5A, 8'h00},
      {4'd10, 2'd1, 3'd7, 8'h00, 8'h5A},
      {4'd10, 2'd0, 3'd5, 8'h00, 8'h00},
      {4'd10, 2'd1, 3'd5, 8'h00, 8'h60},  // R10 status write ignored
      {4'd10, 2'd0, 3'd4, 8'h0B, 8'h00},
      {4'd10, 2'd1, 3'd4, 8'h00, 8'h0B},
      {4'd8,  2'd0, 3'd0, 8'h77, 8'h00},
      {4'd8,  2'd1, 3'd2, 8'h00, 8'hC2},  // R8 write raises txe
      {4'd5,  2'd1, 3'd2, 8'h00, 8'hC1},
      {4'd9,  2'd0, 3'd1, 8'h00, 8'h00},
      {4'd9,  2'd0, 3'd1, 8'h02, 8'h00},
      {4'd9,  2'd1, 3'd2, 8'h00, 8'hC2}   // R9 re-raised
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_regfile #(.RXQ_DEPTH(DEPTH)) u_uart_regfile (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
      .tx_data(tx_data), .irq(irq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic bwrite(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic inject(input logic [7:0] d);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", {7'h0, irq}, 8'h00);
      check("R1 tx_valid", {7'h0, tx_valid}, 8'h00);
      bread(3'd5, v); check("R1 line status", v, 8'h60);
      bread(3'd2, v); check("R1 ident", v, 8'h01);
      bread(3'd3, v); check("R1 line control", v, 8'h00);
      bread(3'd4, v); check("R1 modem control", v, 8'h00);
      bread(3'd1, v); check("R1 enable", v, 8'h00);
      bread(3'd7, v); check("R1 scratch", v, 8'h00);

      for (int i = 0; i < NVEC; i++) begin
         logic [24:0] e;
         string tag;
         e = VEC[i];
         case (e[20:19])
            2'd0: bwrite(e[18:16], e[15:8]);
            2'd2: inject(e[15:8]);
            default: begin
               bread(e[18:16], v);
               tag = $sformatf("R%0d vector %0d", e[24:21], i);
               check(tag, v, e[7:0]);
            end
         endcase
      end

      // R8 transmit pulse
      bwrite(3'd4, 8'h00);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h99;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R8 tx_valid high", {7'h0, tx_valid}, 8'h01);
      check("R8 tx_data", tx_data, 8'h99);
      @(negedge clk);
      check("R8 tx_valid one cycle", {7'h0, tx_valid}, 8'h00);
      bread(3'd2, v); // clear txe

      // R4 irq follows receive enable
      bwrite(3'd1, 8'h01);
      check("R4 irq idle", {7'h0, irq}, 8'h00);
      inject(8'h10);
      check("R4 irq on rx", {7'h0, irq}, 8'h01);
      bwrite(3'd1, 8'h00);
      check("R4 irq gated", {7'h0, irq}, 8'h00);
      bread(3'd0, v); check("R7 drain", v, 8'h10);

      // R8 / R12 loopback
      bwrite(3'd4, 8'h10);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h5C;
      @(negedge clk);
      bus_wr = 1'b0;
      check("R8 loopback no tx", {7'h0, tx_valid}, 8'h00);
      bread(3'd5, v); check("R8 loopback ready", v, 8'h61);
      bread(3'd0, v); check("R8 loopback byte", v, 8'h5C);
      inject(8'hEE);
      bread(3'd5, v); check("R12 rx ignored in loopback", v, 8'h60);
      bread(3'd0, v); check("R12 queue empty", v, 8'h00);
      bwrite(3'd4, 8'h00);

      // R11 overflow drop
      for (int k = 1; k <= DEPTH + 1; k++) inject(8'(k));
      for (int k = 1; k <= DEPTH; k++) begin
         bread(3'd0, v);
         check("R11 queue order", v, 8'(k));
      end
      bread(3'd5, v); check("R11 extra byte dropped", v, 8'h60);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule